// File: doc/BRIEF.md
# Key-Locked GPIO Configuration Register Bank

This block is the register side of a 32-pin general-purpose I/O controller. A host reaches it through a simple word-addressed bus with separate read and write strobes. It holds the pin configuration: output level, output enable, input polarity, open-drain selection, pull-up, pull-down and input mask. It also holds the event trigger settings: level or edge type, both-edge select and per-pin event enable. Every configuration register drives its own output port, so the neighbouring pin and event logic can use it directly. The pin-sampled input word enters on `din_i` and is visible to software as a read-only word.

Output level, output enable and event enable each have a pair of write-only aliases, one that sets bits and one that clears them. Software can change a few pins without a read-modify-write on the bus. A lock protects the whole bank. Any write to either key word while the bank is open seals it. Only a fixed two-word key sequence reopens it.

The lock is a three-state machine. OPEN is the reset state, and the bank is writable there. A write to either key word moves it from OPEN to SEALED. In SEALED, a write of 0xC0DE1248 to the staging key word moves it to ARMED. In ARMED, a write of any other value to the staging key word moves it back to SEALED. A write of 0xC0DEFA73 to the lock word moves it from ARMED to OPEN. All other writes leave the state unchanged.

Top module: `gpio_keybank`

## Requirements
- R1: After reset the bank is open, every register reads zero, and pull-up and pull-down take the values of parameters PU_RST and PD_RST. Their defaults are 0x0F0F0000 and 0x0000F0F0.
- R2: While open, a write of any value to the lock word (0x00) or the staging key word (0x7C) seals the bank, and `locked_o` is high from the next cycle.
- R3: While sealed or armed, writes to every offset other than 0x00 and 0x7C leave all configuration outputs unchanged.
- R4: The bank reopens only on a write of 0xC0DEFA73 to 0x00 while the last value written to 0x7C since sealing is 0xC0DE1248. Reopening clears the staged key, so the next seal needs the full sequence again.
- R5: A write to 0x68 ORs the data into the output level and a write to 0x6C clears the data's set bits from it. A write to 0x70 ORs the data into the output enable and a write to 0x74 clears the data's set bits from it.
- R6: A write to 0x2C ORs the data into the event enable and a write to 0x30 clears the data's set bits from it.
- R7: Reads of the write-only words 0x2C, 0x30, 0x68, 0x6C, 0x70, 0x74 and 0x7C return zero.
- R8: A read of 0x04 returns `din_i` as sampled on the read cycle. Writes to 0x04 change nothing.
- R9: An access to an offset outside the map, or to an address with bits [1:0] not zero, reads zero, writes nothing, and raises `err_o` for exactly the next cycle.
- R10: A read of 0x00 returns 1 while the bank is sealed or armed and 0 while it is open.
- R11: Plain registers take the full written word and drive their output ports from the next cycle. The map is polarity 0x08, output level 0x0C, output enable 0x10, open-drain 0x14, pull-up 0x18, pull-down 0x1C, event type 0x20, both-edge 0x24, event enable 0x28 and input mask 0x34. Read data appears on `rdata_o` in the cycle after `rd_en_i` and is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | 32 | Write data |
| din_i | input | 32 | Sampled pin input word |
| rdata_o | output | 32 | Read data, one cycle after the read |
| err_o | output | 1 | One-cycle pulse after an invalid access |
| locked_o | output | 1 | Bank is sealed or armed |
| pol_o | output | 32 | Input polarity |
| dout_o | output | 32 | Output level |
| oe_o | output | 32 | Output enable |
| odrain_o | output | 32 | Open-drain select |
| pu_o | output | 32 | Pull-up enable |
| pd_o | output | 32 | Pull-down enable |
| imask_o | output | 32 | Input mask |
| evtype_o | output | 32 | Event type (edge when set) |
| evboth_o | output | 32 | Both-edge select |
| even_o | output | 32 | Event enable |

## Verification
A behavioural model, kept as plain variables, is compared with every output on every clock. The stimulus walks opposing bit patterns through each plain register, so a swapped or stuck decode shows up as a mismatch. It then applies overlapping set and clear masks through the aliases, which separates OR and AND-NOT behaviour from plain overwrite. The key sequences include the correct order, the final key without staging, a staged key that is overwritten with junk, and a wrong final key. Each of these differs from the correct sequence by one step, so a premature or missed unlock is caught. The stimulus also covers holes in the map, offsets beyond the map and misaligned addresses, which checks both the error pulse and that such writes change nothing.

// File: rtl/gkb_pkg.sv
package gkb_pkg;
    localparam int DW = 32;
    localparam logic [DW-1:0] KEY_STAGE = 32'hC0DE1248;
    localparam logic [DW-1:0] KEY_OPEN  = 32'hC0DEFA73;

    typedef enum logic [1:0] {
        LK_OPEN,
        LK_SEALED,
        LK_ARMED
    } lk_state_e;

    typedef enum logic [4:0] {
        RID_LOCK, RID_DIN, RID_POL, RID_DOUT, RID_OE, RID_ODR,
        RID_PU, RID_PD, RID_EVTYP, RID_EVBOTH, RID_EVEN,
        RID_EVEN_SET, RID_EVEN_CLR, RID_IMASK,
        RID_DOUT_SET, RID_DOUT_CLR, RID_OE_SET, RID_OE_CLR,
        RID_KEY, RID_NONE
    } rid_e;
endpackage

// File: rtl/gkb_decode.sv
module gkb_decode
    import gkb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output rid_e              rid_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr_i[ADDR_W-1:2];

    always_comb begin
        rid_o = RID_NONE;
        if (addr_i[1:0] == 2'b00) begin
            case (int'(word))
                0:  rid_o = RID_LOCK;
                1:  rid_o = RID_DIN;
                2:  rid_o = RID_POL;
                3:  rid_o = RID_DOUT;
                4:  rid_o = RID_OE;
                5:  rid_o = RID_ODR;
                6:  rid_o = RID_PU;
                7:  rid_o = RID_PD;
                8:  rid_o = RID_EVTYP;
                9:  rid_o = RID_EVBOTH;
                10: rid_o = RID_EVEN;
                11: rid_o = RID_EVEN_SET;
                12: rid_o = RID_EVEN_CLR;
                13: rid_o = RID_IMASK;
                26: rid_o = RID_DOUT_SET;
                27: rid_o = RID_DOUT_CLR;
                28: rid_o = RID_OE_SET;
                29: rid_o = RID_OE_CLR;
                31: rid_o = RID_KEY;
                default: rid_o = RID_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gkb_lockfsm.sv
module gkb_lockfsm
    import gkb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lock_i,
    input  logic          wr_key_i,
    input  logic [DW-1:0] wdata_i,
    output logic          locked_o
);
    lk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (wr_lock_i || wr_key_i) state_d = LK_SEALED;
            end
            LK_SEALED: begin
                if (wr_key_i && wdata_i == KEY_STAGE) state_d = LK_ARMED;
            end
            LK_ARMED: begin
                if (wr_key_i && wdata_i != KEY_STAGE)     state_d = LK_SEALED;
                else if (wr_lock_i && wdata_i == KEY_OPEN) state_d = LK_OPEN;
            end
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        locked_o = (state_q != LK_OPEN);
    end
endmodule

// File: rtl/gkb_regs.sv
module gkb_regs
    import gkb_pkg::*;
#(
    parameter logic [31:0] PU_RST = 32'h0F0F_0000,
    parameter logic [31:0] PD_RST = 32'h0000_F0F0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  rid_e          rid_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] pol_o,
    output logic [DW-1:0] dout_o,
    output logic [DW-1:0] oe_o,
    output logic [DW-1:0] odrain_o,
    output logic [DW-1:0] pu_o,
    output logic [DW-1:0] pd_o,
    output logic [DW-1:0] imask_o,
    output logic [DW-1:0] evtype_o,
    output logic [DW-1:0] evboth_o,
    output logic [DW-1:0] even_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o    <= '0;
            dout_o   <= '0;
            oe_o     <= '0;
            odrain_o <= '0;
            pu_o     <= PU_RST;
            pd_o     <= PD_RST;
            imask_o  <= '0;
            evtype_o <= '0;
            evboth_o <= '0;
            even_o   <= '0;
        end else if (we_i) begin
            case (rid_i)
                RID_POL:      pol_o    <= wdata_i;
                RID_DOUT:     dout_o   <= wdata_i;
                RID_OE:       oe_o     <= wdata_i;
                RID_ODR:      odrain_o <= wdata_i;
                RID_PU:       pu_o     <= wdata_i;
                RID_PD:       pd_o     <= wdata_i;
                RID_IMASK:    imask_o  <= wdata_i;
                RID_EVTYP:    evtype_o <= wdata_i;
                RID_EVBOTH:   evboth_o <= wdata_i;
                RID_EVEN:     even_o   <= wdata_i;
                RID_EVEN_SET: even_o   <= even_o | wdata_i;
                RID_EVEN_CLR: even_o   <= even_o & ~wdata_i;
                RID_DOUT_SET: dout_o   <= dout_o | wdata_i;
                RID_DOUT_CLR: dout_o   <= dout_o & ~wdata_i;
                RID_OE_SET:   oe_o     <= oe_o | wdata_i;
                RID_OE_CLR:   oe_o     <= oe_o & ~wdata_i;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_keybank.sv
module gpio_keybank
    import gkb_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [31:0] PU_RST = 32'h0F0F_0000,
    parameter logic [31:0] PD_RST = 32'h0000_F0F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [31:0]       din_i,
    output logic [31:0]       rdata_o,
    output logic              err_o,
    output logic              locked_o,
    output logic [31:0]       pol_o,
    output logic [31:0]       dout_o,
    output logic [31:0]       oe_o,
    output logic [31:0]       odrain_o,
    output logic [31:0]       pu_o,
    output logic [31:0]       pd_o,
    output logic [31:0]       imask_o,
    output logic [31:0]       evtype_o,
    output logic [31:0]       evboth_o,
    output logic [31:0]       even_o
);
    rid_e          rid;
    logic          locked;
    logic [DW-1:0] rd_mux;

    gkb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .rid_o  (rid)
    );

    gkb_lockfsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lock_i (wr_en_i && rid == RID_LOCK),
        .wr_key_i  (wr_en_i && rid == RID_KEY),
        .wdata_i   (wdata_i),
        .locked_o  (locked)
    );

    gkb_regs #(.PU_RST(PU_RST), .PD_RST(PD_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_en_i && !locked),
        .rid_i    (rid),
        .wdata_i  (wdata_i),
        .pol_o    (pol_o),
        .dout_o   (dout_o),
        .oe_o     (oe_o),
        .odrain_o (odrain_o),
        .pu_o     (pu_o),
        .pd_o     (pd_o),
        .imask_o  (imask_o),
        .evtype_o (evtype_o),
        .evboth_o (evboth_o),
        .even_o   (even_o)
    );

    always_comb begin
        rd_mux = '0;
        case (rid)
            RID_LOCK:   rd_mux = {{(DW-1){1'b0}}, locked};
            RID_DIN:    rd_mux = din_i;
            RID_POL:    rd_mux = pol_o;
            RID_DOUT:   rd_mux = dout_o;
            RID_OE:     rd_mux = oe_o;
            RID_ODR:    rd_mux = odrain_o;
            RID_PU:     rd_mux = pu_o;
            RID_PD:     rd_mux = pd_o;
            RID_IMASK:  rd_mux = imask_o;
            RID_EVTYP:  rd_mux = evtype_o;
            RID_EVBOTH: rd_mux = evboth_o;
            RID_EVEN:   rd_mux = even_o;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            rdata_o <= rd_en_i ? rd_mux : '0;
            err_o   <= (wr_en_i || rd_en_i) && rid == RID_NONE;
        end
    end

    assign locked_o = locked;
endmodule

// File: rtl/gpio_keybank_chk.sv
module gpio_keybank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wdata_i,
    input logic [31:0]       rdata_o,
    input logic              err_o,
    input logic              locked_o,
    input logic [31:0]       pol_o,
    input logic [31:0]       dout_o,
    input logic [31:0]       oe_o,
    input logic [31:0]       even_o
);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(12'h07C);
    localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(12'h068);

    // R2: open bank seals on a key-word write
    p_seal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && wr_en_i && (addr_i == A_LOCK || addr_i == A_KEY)) |=> locked_o);

    // R3: locked bank ignores non-key writes
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && wr_en_i && addr_i != A_LOCK && addr_i != A_KEY)
        |=> ($stable(dout_o) && $stable(oe_o) && $stable(even_o) && $stable(pol_o)));

    // R4: reopening only follows the final key
    p_unlock_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> $past(wr_en_i && addr_i == A_LOCK && wdata_i == 32'hC0DEFA73));

    // R5: set alias ORs into output level
    p_dout_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && wr_en_i && addr_i == A_DSET) |=> dout_o == $past(dout_o | wdata_i));

    // R7: write-only word reads zero
    p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == A_DSET || addr_i == A_KEY)) |=> rdata_o == 32'h0);

    // R9: error pulse only follows an access
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en_i || rd_en_i));
endmodule

bind gpio_keybank gpio_keybank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .locked_o (locked_o),
    .pol_o    (pol_o),
    .dout_o   (dout_o),
    .oe_o     (oe_o),
    .even_o   (even_o)
);

// File: tb/gpio_keybank_bench.sv
module gpio_keybank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] din = '0;
    logic [31:0] rdata, pol, dout, oe, odrain, pu, pd, imask, evtype, evboth, even;
    logic        err, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_keybank u_gpio_keybank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .din_i(din), .rdata_o(rdata),
        .err_o(err), .locked_o(locked), .pol_o(pol), .dout_o(dout),
        .oe_o(oe), .odrain_o(odrain), .pu_o(pu), .pd_o(pd),
        .imask_o(imask), .evtype_o(evtype), .evboth_o(evboth), .even_o(even)
    );

    // reference model
    bit [31:0] m_pol, m_dout, m_oe, m_odr, m_pu, m_pd, m_imask, m_evt, m_evb, m_even;
    bit        m_lock;
    bit [31:0] m_key;
    bit [31:0] m_rdata;
    bit        m_err;
    string     m_rtag = "R11";

    function automatic int kind(input bit [11:0] a);
        // 0 plain/lock/din readable, 1 write-only, 2 invalid
        if (a[1:0] != 0) return 2;
        if (a <= 12'h028 || a == 12'h034) return 0;
        if (a == 12'h02C || a == 12'h030 || (a >= 12'h068 && a <= 12'h074) || a == 12'h07C) return 1;
        return 2;
    endfunction

    function automatic bit [31:0] mread(input bit [11:0] a);
        case (a)
            12'h000: return {31'b0, m_lock};
            12'h004: return din;
            12'h008: return m_pol;
            12'h00C: return m_dout;
            12'h010: return m_oe;
            12'h014: return m_odr;
            12'h018: return m_pu;
            12'h01C: return m_pd;
            12'h020: return m_evt;
            12'h024: return m_evb;
            12'h028: return m_even;
            12'h034: return m_imask;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = 0; m_dout = 0; m_oe = 0; m_odr = 0; m_imask = 0;
            m_evt = 0; m_evb = 0; m_even = 0;
            m_pu = 32'h0F0F_0000; m_pd = 32'h0000_F0F0;
            m_lock = 0; m_key = 0; m_rdata = 0; m_err = 0;
        end else begin
            m_rdata = rd_en ? mread(addr) : 32'h0;
            if (rd_en) begin
                case (kind(addr))
                    1: m_rtag = "R7";
                    2: m_rtag = "R9";
                    default: m_rtag = (addr == 12'h000) ? "R10" :
                                      (addr == 12'h004) ? "R8" : "R11";
                endcase
            end
            m_err = (wr_en || rd_en) && kind(addr) == 2;
            if (wr_en) begin
                if (m_lock) begin
                    if (addr == 12'h07C) m_key = wdata;
                    else if (addr == 12'h000 && m_key == 32'hC0DE1248 && wdata == 32'hC0DEFA73) begin
                        m_lock = 0; m_key = 0;
                    end
                end else begin
                    case (addr)
                        12'h000, 12'h07C: begin m_lock = 1; m_key = 0; end
                        12'h008: m_pol = wdata;
                        12'h00C: m_dout = wdata;
                        12'h010: m_oe = wdata;
                        12'h014: m_odr = wdata;
                        12'h018: m_pu = wdata;
                        12'h01C: m_pd = wdata;
                        12'h020: m_evt = wdata;
                        12'h024: m_evb = wdata;
                        12'h028: m_even = wdata;
                        12'h02C: m_even = m_even | wdata;
                        12'h030: m_even = m_even & ~wdata;
                        12'h034: m_imask = wdata;
                        12'h068: m_dout = m_dout | wdata;
                        12'h06C: m_dout = m_dout & ~wdata;
                        12'h070: m_oe = m_oe | wdata;
                        12'h074: m_oe = m_oe & ~wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare everything on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_rtag, "rdata", rdata, m_rdata);
            chk("R9", "err", {31'b0, err}, {31'b0, m_err});
            chk("R2", "locked", {31'b0, locked}, {31'b0, m_lock});
            chk("R5", "dout", dout, m_dout);
            chk("R5", "oe", oe, m_oe);
            chk("R6", "even", even, m_even);
            chk("R11", "pol", pol, m_pol);
            chk("R11", "odrain", odrain, m_odr);
            chk("R11", "pu", pu, m_pu);
            chk("R11", "pd", pd, m_pd);
            chk("R11", "imask", imask, m_imask);
            chk("R11", "evtype", evtype, m_evt);
            chk("R11", "evboth", evboth, m_evb);
        end
    end

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        @(negedge clk);
        wr_en = 1; rd_en = 0; addr = a; wdata = d;
    endtask

    task automatic rd(input bit [11:0] a);
        @(negedge clk);
        wr_en = 0; rd_en = 1; addr = a; wdata = 32'h0;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "pu reset", pu, 32'h0F0F_0000);
        chk("R1", "pd reset", pd, 32'h0000_F0F0);
        chk("R1", "dout reset", dout, 32'h0);
        chk("R1", "locked reset", {31'b0, locked}, 32'h0);
        rd(12'h000); rd(12'h018); rd(12'h01C); idle();

        // R11: plain registers with opposing patterns
        for (int i = 0; i < 11; i++) begin
            bit [11:0] a;
            a = (i == 10) ? 12'h034 : 12'(12'h008 + 4 * (i % 9));
            if (i == 9) a = 12'h028;
            wr(a, 32'hA5A5_5A5A ^ (32'h1111_1111 * i));
            rd(a);
            wr(a, ~(32'hA5A5_5A5A ^ (32'h1111_1111 * i)));
            rd(a);
        end

        // R5, R6: set/clear aliases with overlapping masks
        wr(12'h00C, 32'h0000_FF00);
        wr(12'h068, 32'h00FF_0F00);
        wr(12'h06C, 32'h0000_F0F0);
        wr(12'h010, 32'h0);
        wr(12'h070, 32'hF000_000F);
        wr(12'h074, 32'h8000_0001);
        wr(12'h028, 32'h0);
        wr(12'h02C, 32'h0330_0330);
        wr(12'h030, 32'h0110_0000);
        idle();
        chk("R5", "dout after set/clear", dout, 32'h00FF_0F00 & ~32'h0000_F0F0 | 32'h0000_0F00 & 32'h0);
        chk("R6", "even after set/clear", even, 32'h0220_0330);

        // R7: write-only words read zero
        rd(12'h02C); rd(12'h030); rd(12'h068); rd(12'h06C);
        rd(12'h070); rd(12'h074); rd(12'h07C);

        // R8: data-in read-only
        din = 32'hDEAD_BEEF;
        rd(12'h004);
        wr(12'h004, 32'h1234_5678);
        din = 32'h0BAD_F00D;
        rd(12'h004);

        // R9: holes, beyond map, misaligned
        wr(12'h038, 32'hFFFF_FFFF); rd(12'h038);
        wr(12'h078, 32'hFFFF_FFFF); rd(12'h078);
        rd(12'h080); wr(12'hFFC, 32'h1);
        wr(12'h00D, 32'hFFFF_FFFF); rd(12'h00E);
        idle(); idle();

        // R2: seal via staging word, then R3: writes ignored
        wr(12'h07C, 32'h5555_5555);
        rd(12'h000);
        wr(12'h00C, 32'h0);
        wr(12'h068, 32'hFFFF_FFFF);
        wr(12'h074, 32'hFFFF_FFFF);
        wr(12'h02C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0);
        idle();
        chk("R3", "dout frozen while locked", dout, m_dout);
        chk("R10", "locked flag", {31'b0, locked}, 32'h1);

        // R4: wrong sequences keep it locked
        wr(12'h000, 32'hC0DE_FA73);         // final key without staging
        wr(12'h07C, 32'hC0DE_1248);
        wr(12'h07C, 32'h0000_0001);         // staged key overwritten
        wr(12'h000, 32'hC0DE_FA73);
        wr(12'h07C, 32'hC0DE_1248);
        wr(12'h000, 32'hC0DE_FA74);         // wrong final key
        idle();
        chk("R4", "still locked after bad sequences", {31'b0, locked}, 32'h1);
        wr(12'h000, 32'hC0DE_FA73);         // correct completion
        idle();
        chk("R4", "unlocked after key", {31'b0, locked}, 32'h0);
        rd(12'h000);

        // R2: seal via lock word, R4: full sequence needed again
        wr(12'h000, 32'h0);
        wr(12'h000, 32'hC0DE_FA73);
        idle();
        chk("R4", "staged key cleared on reopen", {31'b0, locked}, 32'h1);
        wr(12'h07C, 32'hC0DE_1248);
        wr(12'h000, 32'hC0DE_FA73);
        wr(12'h00C, 32'h1357_9BDF);
        rd(12'h00C);
        idle(); idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule